// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Matcher

This block watches a running calendar clock and raises an alarm when the time reaches a programmed point. It has two independent alarms. The first stores seconds, minutes, hours and a day-or-date byte. The second stores minutes, hours and a day-or-date byte, and it can only fire when the seconds are zero. The time values arrive on input ports in packed BCD. A strobe marks the once-per-second update, and that strobe is the only moment at which the alarms are compared.

Bit 7 of every alarm byte is a "don't care" mask for its field. Setting masks from the least significant field upward chooses the repeat rate: every second, every minute, or once per hour, day or date. Each alarm has a sticky flag. A flag is set on a match whatever the interrupt enables and the pin mode say. Software clears a flag by writing 0 to its bit, and writing 1 leaves it as it was. The active-low output pin has two modes. In interrupt mode it reports any enabled flag. In the other mode it passes through a square wave that is generated elsewhere.

Hour bytes carry their own 12/24 format. Both the alarm hour and the current hour are reduced to a 0-23 value before they are compared, so an alarm written in one format matches a clock running in the other.

Top module: `tod_alarm_unit`

## Requirements
- R1: Out of reset both flags read 0. The pin mode is interrupt, both enables are 0, the pin is high, and every alarm byte is 0x00.
- R2: Alarm 1 occupies write addresses 0 to 3 (seconds, minutes, hours, day/date). With all four mask bits (bit 7) set, alarm 1 fires on every update strobe.
- R3: Alarm 1 field matching follows the masks. Masking only the upper three fields matches on seconds alone. Masking the upper two matches on minutes and seconds. Masking only day/date matches on hours, minutes and seconds. A mismatch in any unmasked field leaves the flag clear.
- R4: In a day/date byte, bit 6 chooses the target. When bit 6 is 1, bits 3:0 are compared with the day of week. When bit 6 is 0, bits 5:0 are compared with the date.
- R5: Alarm 2 occupies addresses 4 to 6 (minutes, hours, day/date). It uses the same masks and fires only on an update whose seconds equal 00.
- R6: Matching happens only in a cycle where the update strobe is high. Matching time inputs with no strobe leave the flags unchanged.
- R7: A match sets its flag even when its enable is 0 or the square-wave mode is selected.
- R8: The control byte sits at address 7: bit 2 is the mode (1 = interrupt), bit 1 enables alarm 2 and bit 0 enables alarm 1. In interrupt mode the pin is low exactly when some flag is set together with its enable.
- R9: When the mode bit is 0, the pin follows the square-wave input, whatever the flags and enables are.
- R10: The flag byte sits at address 8, with bit 0 for alarm 1 and bit 1 for alarm 2. Writing 0 to a bit clears that flag, and writing 1 leaves it unchanged.
- R11: If a match and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R12: An hour byte uses bit 6 to select the format. When bit 6 is 1 the byte is 12-hour: bit 5 is PM and bits 4:0 hold BCD 1-12. When bit 6 is 0 the byte is 24-hour, with bits 5:0 holding BCD 0-23. Hours compare after normalisation, so 12 AM equals 00 and 7 PM equals 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Once-per-second update strobe; the time inputs are valid while it is high |
| now_sec_i | input | 7 | Current seconds, BCD |
| now_min_i | input | 7 | Current minutes, BCD |
| now_hour_i | input | 7 | Current hours: bit 6 selects 12-hour format, bit 5 is PM or tens, bits 4:0 are BCD |
| now_wday_i | input | 3 | Current day of week, 1-7 |
| now_mday_i | input | 6 | Current date, BCD |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register write address |
| cfg_wdata_i | input | 8 | Register write data |
| sqw_i | input | 1 | Square wave passed to the pin when the mode bit is 0 |
| flag_o | output | 2 | Sticky flags: bit 0 for alarm 1, bit 1 for alarm 2 |
| irq_n_o | output | 1 | Active-low interrupt or square-wave pin |

## Verification
The assertions assume that the time inputs change only on an update strobe or while the strobe is low, and that a clearing write and a match are the only events that move a flag. They also assume the pin can change in interrupt mode only through a write or a strobe. The stimulus drives each operation on the falling edge and holds it for exactly one clock. It raises the strobe only in the cycles that are meant to be compared, and it keeps the square-wave input and the control writes in separate cycles. Time values stay inside the legal BCD ranges, and the mask patterns are limited to the listed repeat rates.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [6:0] hour;
      logic [2:0] wday;
      logic [5:0] mday;
   } tod_t;

   // Reduce a BCD hour field (bit 6 = 12-hour format) to a 0..23 binary value.
   function automatic logic [4:0] hour_norm(input logic [6:0] h);
      logic [4:0] ones;
      logic [4:0] v;
      ones = {1'b0, h[3:0]};
      if (h[6]) begin
         v = (h[4] ? 5'd10 : 5'd0) + ones;
         if (v == 5'd12) v = 5'd0;
         if (h[5]) v = v + 5'd12;
      end else begin
         v = (h[5] ? 5'd20 : (h[4] ? 5'd10 : 5'd0)) + ones;
      end
      return v;
   endfunction

endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs #(
   parameter int ADDR_W    = 4,
   parameter int A1_BYTES  = 4,
   parameter int A2_BYTES  = 3,
   parameter int A1_BASE   = 0,
   parameter int A2_BASE   = 4,
   parameter int CTRL_ADDR = 7,
   parameter int MODE_BIT  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [7:0]               wdata_i,
   output logic [A1_BYTES-1:0][7:0] a1_o,
   output logic [A2_BYTES-1:0][7:0] a2_o,
   output logic                     mode_o,
   output logic [1:0]               en_o
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   if (MODE_BIT < 2 || MODE_BIT > 7) begin : g_bad_mode_bit
      $error("tod_alarm_regs: MODE_BIT must lie in 2..7");
   end
   if ((A1_BASE + A1_BYTES > A2_BASE) || (A2_BASE + A2_BYTES > CTRL_ADDR)) begin : g_bad_map
      $error("tod_alarm_regs: register windows overlap");
   end

   for (genvar i = 0; i < A1_BYTES; i++) begin : g_a1
      localparam logic [ADDR_W-1:0] ADR = ADDR_W'(A1_BASE + i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     a1_o[i] <= 8'h00;
         else if (we_i && addr_i == ADR) a1_o[i] <= wdata_i;
      end
   end

   for (genvar i = 0; i < A2_BYTES; i++) begin : g_a2
      localparam logic [ADDR_W-1:0] ADR = ADDR_W'(A2_BASE + i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     a2_o[i] <= 8'h00;
         else if (we_i && addr_i == ADR) a2_o[i] <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= 1'b1;
         en_o   <= 2'b00;
      end else if (we_i && addr_i == CTRL_A) begin
         mode_o <= wdata_i[MODE_BIT];
         en_o   <= wdata_i[1:0];
      end
   end

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
   import tod_alarm_pkg::*;
#(
   parameter int NBYTES  = 4,
   parameter bit HAS_SEC = 1'b1
) (
   input  logic [NBYTES-1:0][7:0] alarm_i,
   input  tod_t                   now_i,
   output logic                   match_o
);

   localparam int OFS  = HAS_SEC ? 0 : 1;
   localparam int IMIN = 1 - OFS;
   localparam int IHR  = 2 - OFS;
   localparam int IDD  = 3 - OFS;

   if (NBYTES != (HAS_SEC ? 4 : 3)) begin : g_bad_nbytes
      $error("tod_alarm_match: NBYTES does not fit HAS_SEC");
   end

   logic sec_ok, min_ok, hr_ok, dd_ok, dd_eq;

   if (HAS_SEC) begin : g_sec_field
      always_comb sec_ok = alarm_i[0][7] | (alarm_i[0][6:0] == now_i.sec);
   end else begin : g_sec_zero
      always_comb sec_ok = (now_i.sec == 7'h00);
   end

   always_comb begin
      min_ok = alarm_i[IMIN][7] | (alarm_i[IMIN][6:0] == now_i.min);
      hr_ok  = alarm_i[IHR][7]
             | (hour_norm(alarm_i[IHR][6:0]) == hour_norm(now_i.hour));
      if (alarm_i[IDD][6]) dd_eq = (alarm_i[IDD][3:0] == {1'b0, now_i.wday});
      else                 dd_eq = (alarm_i[IDD][5:0] == now_i.mday);
      dd_ok   = alarm_i[IDD][7] | dd_eq;
      match_o = sec_ok & min_ok & hr_ok & dd_ok;
   end

endmodule

// File: rtl/tod_alarm_flags.sv
module tod_alarm_flags #(
   parameter int N_ALARM = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_ALARM-1:0] hit_i,
   input  logic               clr_we_i,
   input  logic [N_ALARM-1:0] keep_i,
   input  logic               mode_i,
   input  logic [N_ALARM-1:0] en_i,
   input  logic               sqw_i,
   output logic [N_ALARM-1:0] flag_o,
   output logic               pin_n_o
);

   if (N_ALARM < 1) begin : g_bad_n
      $error("tod_alarm_flags: N_ALARM must be at least 1");
   end

   for (genvar i = 0; i < N_ALARM; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_o[i] <= 1'b0;
         else if (hit_i[i]) flag_o[i] <= 1'b1;
         else if (clr_we_i) flag_o[i] <= flag_o[i] & keep_i[i];
      end
   end

   always_comb pin_n_o = mode_i ? ~|(flag_o & en_i) : sqw_i;

endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
   import tod_alarm_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int A1_BASE   = 0,
   parameter int A2_BASE   = 4,
   parameter int CTRL_ADDR = 7,
   parameter int FLAG_ADDR = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [6:0]        now_sec_i,
   input  logic [6:0]        now_min_i,
   input  logic [6:0]        now_hour_i,
   input  logic [2:0]        now_wday_i,
   input  logic [5:0]        now_mday_i,
   input  logic              cfg_we_i,
   input  logic [ADDR_W-1:0] cfg_addr_i,
   input  logic [7:0]        cfg_wdata_i,
   input  logic              sqw_i,
   output logic [1:0]        flag_o,
   output logic              irq_n_o
);

   localparam int A1_BYTES = 4;
   localparam int A2_BYTES = 3;
   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

   if (FLAG_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("tod_alarm_unit: register address does not fit ADDR_W");
   end
   if (FLAG_ADDR == CTRL_ADDR) begin : g_bad_flag_addr
      $error("tod_alarm_unit: flag and control addresses collide");
   end

   logic [A1_BYTES-1:0][7:0] a1_q;
   logic [A2_BYTES-1:0][7:0] a2_q;
   logic                     mode_q;
   logic [1:0]               en_q;
   logic [1:0]               match;
   logic [1:0]               hit;
   logic                     clr_we;
   tod_t                     now;

   always_comb begin
      now.sec  = now_sec_i;
      now.min  = now_min_i;
      now.hour = now_hour_i;
      now.wday = now_wday_i;
      now.mday = now_mday_i;
      hit      = tick_i ? match : 2'b00;
      clr_we   = cfg_we_i && (cfg_addr_i == FLAG_A);
   end

   tod_alarm_regs #(
      .ADDR_W(ADDR_W), .A1_BYTES(A1_BYTES), .A2_BYTES(A2_BYTES),
      .A1_BASE(A1_BASE), .A2_BASE(A2_BASE), .CTRL_ADDR(CTRL_ADDR), .MODE_BIT(2)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
      .wdata_i(cfg_wdata_i), .a1_o(a1_q), .a2_o(a2_q), .mode_o(mode_q), .en_o(en_q)
   );

   tod_alarm_match #(.NBYTES(A1_BYTES), .HAS_SEC(1'b1)) u_match1 (
      .alarm_i(a1_q), .now_i(now), .match_o(match[0])
   );

   tod_alarm_match #(.NBYTES(A2_BYTES), .HAS_SEC(1'b0)) u_match2 (
      .alarm_i(a2_q), .now_i(now), .match_o(match[1])
   );

   tod_alarm_flags #(.N_ALARM(2)) u_flags (
      .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_we_i(clr_we),
      .keep_i(cfg_wdata_i[1:0]), .mode_i(mode_q), .en_i(en_q), .sqw_i(sqw_i),
      .flag_o(flag_o), .pin_n_o(irq_n_o)
   );

endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk #(
   parameter int ADDR_W    = 4,
   parameter int FLAG_ADDR = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              cfg_we_i,
   input logic [ADDR_W-1:0] cfg_addr_i,
   input logic [1:0]        keep_i,
   input logic [1:0]        flag_o,
   input logic              irq_n_o,
   input logic              mode_q
);

   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

   logic clr_wr;
   always_comb clr_wr = cfg_we_i && (cfg_addr_i == FLAG_A);

   // R6: a flag may only rise after an update strobe
   assert_flag1_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[0]) |-> $past(tick_i));
   assert_flag2_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[1]) |-> $past(tick_i));

   // R10: writing 0 clears the flag when no match competes
   assert_clear1_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !keep_i[0] && !tick_i) |=> !flag_o[0]);
   assert_clear2_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !keep_i[1] && !tick_i) |=> !flag_o[1]);

   // R10: flags are sticky unless a 0 is written
   assert_sticky1_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[0] && !(clr_wr && !keep_i[0])) |=> flag_o[0]);
   assert_sticky2_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[1] && !(clr_wr && !keep_i[1])) |=> flag_o[1]);

   // R8: in interrupt mode a low pin needs at least one flag
   assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !irq_n_o) |-> (flag_o != 2'b00));

   // R8: in interrupt mode the pin cannot move without a write or a strobe
   assert_irq_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !tick_i && !cfg_we_i) |=> $stable(irq_n_o));

endmodule

bind tod_alarm_unit tod_alarm_chk #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_we_i(cfg_we_i),
   .cfg_addr_i(cfg_addr_i), .keep_i(cfg_wdata_i[1:0]), .flag_o(flag_o),
   .irq_n_o(irq_n_o), .mode_q(mode_q)
);

// File: tb/tb_tod_alarm_unit.sv
module tb_tod_alarm_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [6:0] sec = '0, mnt = '0, hr = '0;
   logic [2:0] wday = 3'd1;
   logic [5:0] mday = 6'h01;
   logic       we = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       sqw = 1'b0;
   logic [1:0] flag;
   logic       irq_n;

   // next-cycle stimulus shadows
   logic [6:0] n_sec = 7'h56, n_min = 7'h34, n_hr = 7'h12;
   logic [2:0] n_wday = 3'd3;
   logic [5:0] n_mday = 6'h05;
   logic       n_sqw = 1'b0;

   int total = 0;
   int bad = 0;
   int mcyc = 0;
   bit done = 1'b0;

   typedef struct {
      int         due;
      logic [1:0] flags;
      logic       pin;
      string      tag;
   } exp_t;
   exp_t sbq[$];

   always #2 clk = ~clk;

   tod_alarm_unit dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .now_sec_i(sec), .now_min_i(mnt), .now_hour_i(hr),
      .now_wday_i(wday), .now_mday_i(mday),
      .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
      .sqw_i(sqw), .flag_o(flag), .irq_n_o(irq_n)
   );

   // monitor: pops expected items once the design has had its edge
   always @(posedge clk) begin
      #1;
      mcyc++;
      while (sbq.size() > 0 && sbq[0].due <= mcyc) begin
         exp_t e;
         e = sbq.pop_front();
         total++;
         if (flag !== e.flags || irq_n !== e.pin) begin
            bad++;
            $display("FAIL %s: flags=%b pin=%b expected flags=%b pin=%b",
                     e.tag, flag, irq_n, e.flags, e.pin);
         end
      end
   end

   task automatic set_time(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                           input logic [2:0] w, input logic [5:0] d);
      n_sec = s; n_min = m; n_hr = h; n_wday = w; n_mday = d;
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input logic w_en, input logic [3:0] a, input logic [7:0] d,
                       input logic tk, input logic [1:0] ef, input logic ep, input string tag);
      @(negedge clk);
      we = w_en; addr = a; wdata = d; tick = tk;
      sec = n_sec; mnt = n_min; hr = n_hr; wday = n_wday; mday = n_mday; sqw = n_sqw;
      sbq.push_back('{due: mcyc + 1, flags: ef, pin: ep, tag: tag});
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d,
                     input logic [1:0] ef, input logic ep, input string tag);
      step(1'b1, a, d, 1'b0, ef, ep, tag);
   endtask

   task automatic tk(input logic [1:0] ef, input logic ep, input string tag);
      step(1'b0, 4'd0, 8'h00, 1'b1, ef, ep, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 4'd0, 8'h00, 1'b0, 2'b00, 1'b1, "R1 reset state");
      tk(2'b00, 1'b1, "R1 zero alarms no match");

      // R2: all masks set
      wr(4'd0, 8'h80, 2'b00, 1'b1, "R2 cfg");
      wr(4'd1, 8'h80, 2'b00, 1'b1, "R2 cfg");
      wr(4'd2, 8'h80, 2'b00, 1'b1, "R2 cfg");
      wr(4'd3, 8'h80, 2'b00, 1'b1, "R2 cfg");
      tk(2'b01, 1'b1, "R2 every second / R7 enable off");
      wr(4'd8, 8'h02, 2'b00, 1'b1, "R10 write zero clears");

      // R3: seconds, then minutes+seconds
      wr(4'd0, 8'h45, 2'b00, 1'b1, "R3 cfg");
      set_time(7'h44, 7'h29, 7'h07, 3'd3, 6'h05);
      tk(2'b00, 1'b1, "R3 seconds mismatch");
      set_time(7'h45, 7'h29, 7'h07, 3'd3, 6'h05);
      tk(2'b01, 1'b1, "R3 seconds match");
      wr(4'd8, 8'h00, 2'b00, 1'b1, "R10 clear");
      wr(4'd1, 8'h30, 2'b00, 1'b1, "R3 cfg");
      tk(2'b00, 1'b1, "R3 minutes mismatch");
      set_time(7'h45, 7'h30, 7'h07, 3'd3, 6'h05);
      tk(2'b01, 1'b1, "R3 minutes seconds match");
      wr(4'd8, 8'h00, 2'b00, 1'b1, "R10 clear");

      // R12: hours, mixed formats
      wr(4'd2, 8'h67, 2'b00, 1'b1, "R12 cfg 7PM");
      tk(2'b00, 1'b1, "R12 07 vs 7PM");
      set_time(7'h45, 7'h30, 7'h19, 3'd3, 6'h05);
      tk(2'b01, 1'b1, "R12 19 vs 7PM / R3 hms");
      wr(4'd8, 8'h00, 2'b00, 1'b1, "R10 clear");
      wr(4'd2, 8'h52, 2'b00, 1'b1, "R12 cfg 12AM");
      set_time(7'h45, 7'h30, 7'h12, 3'd3, 6'h05);
      tk(2'b00, 1'b1, "R12 noon vs 12AM");
      set_time(7'h45, 7'h30, 7'h00, 3'd3, 6'h09);
      tk(2'b01, 1'b1, "R12 00 vs 12AM");
      wr(4'd8, 8'h00, 2'b00, 1'b1, "R10 clear");

      // R4: day or date target
      wr(4'd3, 8'h43, 2'b00, 1'b1, "R4 cfg day 3");
      tk(2'b01, 1'b1, "R4 day match");
      wr(4'd8, 8'h00, 2'b00, 1'b1, "R10 clear");
      set_time(7'h45, 7'h30, 7'h00, 3'd4, 6'h03);
      tk(2'b00, 1'b1, "R4 day mismatch though date equals 3");
      wr(4'd3, 8'h09, 2'b00, 1'b1, "R4 cfg date 9");
      set_time(7'h45, 7'h30, 7'h00, 3'd4, 6'h09);
      tk(2'b01, 1'b1, "R4 date match");
      wr(4'd8, 8'h00, 2'b00, 1'b1, "R10 clear");

      // R6: matching time without strobe
      step(1'b0, 4'd0, 8'h00, 1'b0, 2'b00, 1'b1, "R6 no strobe no flag");
      // R11: set beats clear
      step(1'b1, 4'd8, 8'h00, 1'b1, 2'b01, 1'b1, "R11 set wins over clear");
      wr(4'd8, 8'h01, 2'b01, 1'b1, "R10 write one keeps");
      wr(4'd8, 8'h00, 2'b00, 1'b1, "R10 clear");

      // retire alarm 1, exercise alarm 2
      wr(4'd0, 8'h59, 2'b00, 1'b1, "cfg");
      wr(4'd4, 8'h80, 2'b00, 1'b1, "R5 cfg");
      wr(4'd5, 8'h80, 2'b00, 1'b1, "R5 cfg");
      wr(4'd6, 8'h80, 2'b00, 1'b1, "R5 cfg");
      set_time(7'h30, 7'h14, 7'h08, 3'd2, 6'h20);
      tk(2'b00, 1'b1, "R5 seconds not zero");
      set_time(7'h00, 7'h14, 7'h08, 3'd2, 6'h20);
      tk(2'b10, 1'b1, "R5 once per minute");
      wr(4'd8, 8'h01, 2'b00, 1'b1, "R10 clear alarm 2");
      wr(4'd4, 8'h15, 2'b00, 1'b1, "R5 cfg");
      tk(2'b00, 1'b1, "R5 minutes mismatch");
      set_time(7'h00, 7'h15, 7'h08, 3'd2, 6'h20);
      tk(2'b10, 1'b1, "R5 minutes match");
      wr(4'd8, 8'h00, 2'b00, 1'b1, "R10 clear");
      wr(4'd5, 8'h08, 2'b00, 1'b1, "R5 cfg");
      wr(4'd6, 8'h21, 2'b00, 1'b1, "R5 cfg");
      tk(2'b00, 1'b1, "R5 date mismatch");
      set_time(7'h00, 7'h15, 7'h08, 3'd2, 6'h21);
      tk(2'b10, 1'b1, "R5 full match");

      // R8: interrupt gating
      wr(4'd7, 8'h05, 2'b10, 1'b1, "R8 wrong enable");
      wr(4'd7, 8'h06, 2'b10, 1'b0, "R8 enabled flag drives low");
      wr(4'd8, 8'h00, 2'b00, 1'b1, "R8 pin released on clear");

      // R9: square-wave mode
      wr(4'd7, 8'h02, 2'b00, 1'b0, "R9 follows sqw low");
      n_sqw = 1'b1;
      tk(2'b10, 1'b1, "R9 follows sqw high / R7 flag in sqw mode");
      n_sqw = 1'b0;
      step(1'b0, 4'd0, 8'h00, 1'b0, 2'b10, 1'b0, "R9 follows sqw low again");
      wr(4'd7, 8'h06, 2'b10, 1'b0, "R8 back to interrupt");
      step(1'b0, 4'd0, 8'h00, 1'b0, 2'b10, 1'b0, "R8 hold");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule